// File: doc/BRIEF.md
# TDM Slot Selector

The slot selector runs beside a serial port and decides, word by word, which slots of a time-division-multiplexed frame carry traffic. It holds two independent copies of the same engine, one for the transmit side and one for the receive side. Each copy watches its own bit-clock tick and frame sync. It waits a programmed number of bit times after the sync, counts bits into words of a programmed length and numbers the words as slots. It then looks each slot up in two relocatable 16-slot enable partitions.

Both engines run in the system clock domain. A bit clock is presented as a one-cycle `*_bit_tick` strobe, and frame sync is sampled only on cycles that carry a tick. For every data bit, the engine reports the slot it belongs to and whether that slot is enabled. It also pulses at the first and last bit of every word. The transmit engine holds a data-enable level for the bit interval. The receive engine pulses a take strobe when a complete enabled word has arrived.

Top module: `tdm_slot_selector`

## Requirements
- R1: After reset every output is 0, and no data bit is counted until a frame sync has been seen.
- R2: With `*_fs_invert` = 0, a frame sync is a tick on which `*_fsync` is 1. With `*_fs_invert` = 1, it is a tick on which `*_fsync` is 0. The level of `*_fsync` on cycles without a tick has no effect.
- R3: The delay code sets where bit 0 of slot 0 falls. Code 0 puts it on the sync tick itself. Code 1 puts it on the next tick. Code 2 puts it on the second tick after the sync. Code 3 behaves as code 2.
- R4: The word length code sets the bits per word: 0=8, 1=12, 2=16, 3=20, 4=24, 5=32, and 6 and 7 also give 32. `*_word_start` is a one-clock pulse in the cycle after the tick that carries bit 0 of a word. `*_word_end` is the same for the last bit of the word.
- R5: `*_slot` is the slot number of the most recent data bit. It is 0 for the first word after a sync and rises by one per word. It changes only together with `*_word_start`.
- R6: A frame holds at most 128 slots. After the last bit of slot 127, no data bit is counted until the next frame sync.
- R7: A frame sync that arrives inside a frame abandons the current word and restarts at slot 0, with the programmed delay applied again.
- R8: Slot s is enabled when partition A matches or partition B matches. Partition A matches when s[6:4] equals `*_blk_a` and bit s[3:0] of `*_mask_a` is 1. Partition B is the same with `*_blk_b` and `*_mask_b`. `*_slot_en` gives this value for the slot of the most recent data bit.
- R9: `tx_data_en` is 1 after a transmit tick that carries a bit of an enabled slot. It is 0 after any other transmit tick, and it holds between ticks.
- R10: `rx_word_take` pulses together with `rx_word_end` only when the word's slot is enabled. A disabled slot gives no take strobe.
- R11: The transmit and receive engines share no state or configuration. Ticks, syncs and settings on one side leave the other side's outputs unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tx_bit_tick | input | 1 | Transmit bit-clock strobe |
| tx_fsync | input | 1 | Transmit frame sync level |
| tx_fs_invert | input | 1 | Transmit sync is active low when 1 |
| tx_delay | input | 2 | Transmit data delay code |
| tx_wlen | input | 3 | Transmit word length code |
| tx_blk_a | input | 3 | Transmit partition A block number |
| tx_blk_b | input | 3 | Transmit partition B block number |
| tx_mask_a | input | 16 | Transmit partition A slot enables |
| tx_mask_b | input | 16 | Transmit partition B slot enables |
| rx_bit_tick | input | 1 | Receive bit-clock strobe |
| rx_fsync | input | 1 | Receive frame sync level |
| rx_fs_invert | input | 1 | Receive sync is active low when 1 |
| rx_delay | input | 2 | Receive data delay code |
| rx_wlen | input | 3 | Receive word length code |
| rx_blk_a | input | 3 | Receive partition A block number |
| rx_blk_b | input | 3 | Receive partition B block number |
| rx_mask_a | input | 16 | Receive partition A slot enables |
| rx_mask_b | input | 16 | Receive partition B slot enables |
| tx_slot | output | 7 | Transmit slot of latest data bit |
| tx_word_start | output | 1 | Transmit first-bit pulse |
| tx_word_end | output | 1 | Transmit last-bit pulse |
| tx_slot_en | output | 1 | Transmit slot enabled |
| tx_data_en | output | 1 | Transmit data-enable for the current bit |
| rx_slot | output | 7 | Receive slot of latest data bit |
| rx_word_start | output | 1 | Receive first-bit pulse |
| rx_word_end | output | 1 | Receive last-bit pulse |
| rx_slot_en | output | 1 | Receive slot enabled |
| rx_word_take | output | 1 | Receive enabled-word-complete pulse |

## Verification
Every result comes from a single register stage that loads on the clock edge sampling a tick. The word start, word end and take pulses are valid only in the one clock cycle after that edge. Slot, slot enable and data enable stay valid until the next tick. The bench raises a tick for one cycle and reads all outputs on the falling edge that follows the sampling edge. It then leaves an idle cycle before the next tick, so a pulse that stays high one cycle too long appears at the next read. The expected values are recomputed at each read from the number of ticks since the last sync, using division and remainder by the word length.

// File: rtl/tdm_sel_pkg.sv
`timescale 1ns/1ps
package tdm_sel_pkg;

  typedef enum logic [1:0] {
    DLY_NONE = 2'd0,
    DLY_ONE  = 2'd1,
    DLY_TWO  = 2'd2,
    DLY_RSVD = 2'd3
  } dly_code_e;

  // Number of ticks between sync and first data bit; reserved code acts as two.
  function automatic logic [1:0] eff_delay(input logic [1:0] code);
    if (code == DLY_RSVD) return 2'd2;
    return code;
  endfunction

  // Bits per word for a length code; unused codes select the longest word.
  function automatic int unsigned wlen_bits(input logic [2:0] code);
    case (code)
      3'd0:    return 8;
      3'd1:    return 12;
      3'd2:    return 16;
      3'd3:    return 20;
      3'd4:    return 24;
      default: return 32;
    endcase
  endfunction

endpackage

// File: rtl/tdm_frame_tracker.sv
`timescale 1ns/1ps
module tdm_frame_tracker #(
  parameter int NUM_SLOTS = 128,
  parameter int MAX_WLEN  = 32,
  localparam int SLOT_W   = $clog2(NUM_SLOTS),
  localparam int POS_W    = $clog2(MAX_WLEN)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              fsync,
  input  logic              fs_invert,
  input  logic [1:0]        delay,
  input  logic [2:0]        wlen,
  output logic              bit_evt,
  output logic [SLOT_W-1:0] evt_slot,
  output logic              evt_first,
  output logic              evt_last
);
  import tdm_sel_pkg::*;

  logic              run_q;
  logic [1:0]        wait_q;
  logic [POS_W-1:0]  pos_q;
  logic [SLOT_W-1:0] slot_q;

  logic             fs_hit;
  logic [1:0]       dly;
  logic             starting;
  logic             continuing;
  logic [POS_W-1:0] evt_pos;

  assign fs_hit     = tick & (fsync ^ fs_invert);
  assign dly        = eff_delay(delay);
  assign starting   = (fs_hit & (dly == 2'd0)) |
                      (tick & ~fs_hit & (wait_q == 2'd1));
  assign continuing = tick & ~fs_hit & run_q & (wait_q == 2'd0);
  assign bit_evt    = starting | continuing;
  assign evt_pos    = starting ? '0 : pos_q;
  assign evt_slot   = starting ? '0 : slot_q;
  assign evt_first  = bit_evt & (evt_pos == '0);
  assign evt_last   = bit_evt & (evt_pos == POS_W'(wlen_bits(wlen) - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      wait_q <= 2'd0;
      pos_q  <= '0;
      slot_q <= '0;
    end else begin
      if (fs_hit) begin
        run_q  <= 1'b0;
        wait_q <= dly;
        pos_q  <= '0;
        slot_q <= '0;
      end else if (tick && wait_q > 2'd1) begin
        wait_q <= wait_q - 2'd1;
      end
      if (bit_evt) begin
        wait_q <= 2'd0;
        if (evt_last) begin
          pos_q <= '0;
          if (evt_slot == SLOT_W'(NUM_SLOTS - 1)) begin
            run_q  <= 1'b0;
            slot_q <= '0;
          end else begin
            run_q  <= 1'b1;
            slot_q <= evt_slot + 1'b1;
          end
        end else begin
          run_q  <= 1'b1;
          pos_q  <= evt_pos + 1'b1;
          slot_q <= evt_slot;
        end
      end
    end
  end

endmodule

// File: rtl/tdm_chan_map.sv
`timescale 1ns/1ps
module tdm_chan_map #(
  parameter int NUM_SLOTS = 128,
  parameter int PART_CH   = 16,
  localparam int SLOT_W   = $clog2(NUM_SLOTS),
  localparam int IDX_W    = $clog2(PART_CH),
  localparam int BLK_W    = SLOT_W - IDX_W
) (
  input  logic [SLOT_W-1:0]  slot,
  input  logic [BLK_W-1:0]   blk_a,
  input  logic [BLK_W-1:0]   blk_b,
  input  logic [PART_CH-1:0] mask_a,
  input  logic [PART_CH-1:0] mask_b,
  output logic               enabled
);
  logic [BLK_W-1:0]        blk;
  logic [IDX_W-1:0]        idx;
  logic [1:0][BLK_W-1:0]   part_blk;
  logic [1:0][PART_CH-1:0] part_mask;
  logic [1:0]              part_hit;

  assign blk       = slot[SLOT_W-1:IDX_W];
  assign idx       = slot[IDX_W-1:0];
  assign part_blk  = {blk_b, blk_a};
  assign part_mask = {mask_b, mask_a};

  for (genvar p = 0; p < 2; p++) begin : g_part
    assign part_hit[p] = (blk == part_blk[p]) & part_mask[p][idx];
  end

  assign enabled = |part_hit;

endmodule

// File: rtl/tdm_out_stage.sv
`timescale 1ns/1ps
module tdm_out_stage #(
  parameter int SLOT_W = 7,
  parameter bit IS_TX  = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              bit_evt,
  input  logic [SLOT_W-1:0] evt_slot,
  input  logic              evt_first,
  input  logic              evt_last,
  input  logic              enabled,
  output logic [SLOT_W-1:0] slot_idx,
  output logic              word_start,
  output logic              word_end,
  output logic              slot_en,
  output logic              xfer
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot_idx   <= '0;
      word_start <= 1'b0;
      word_end   <= 1'b0;
      slot_en    <= 1'b0;
    end else begin
      word_start <= evt_first;
      word_end   <= evt_last;
      if (bit_evt) begin
        slot_idx <= evt_slot;
        slot_en  <= enabled;
      end
    end
  end

  if (IS_TX) begin : g_tx
    // level: enabled data bit in the interval after the latest tick
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       xfer <= 1'b0;
      else if (bit_evt) xfer <= enabled;
      else if (tick)    xfer <= 1'b0;
    end
  end else begin : g_rx
    // pulse: an enabled word has just completed
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) xfer <= 1'b0;
      else        xfer <= evt_last & enabled;
    end
  end

endmodule

// File: rtl/tdm_slot_selector.sv
`timescale 1ns/1ps
module tdm_slot_selector #(
  parameter int NUM_SLOTS = 128,
  parameter int PART_CH   = 16,
  parameter int MAX_WLEN  = 32,
  localparam int SLOT_W   = $clog2(NUM_SLOTS),
  localparam int BLK_W    = SLOT_W - $clog2(PART_CH)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tx_bit_tick,
  input  logic               tx_fsync,
  input  logic               tx_fs_invert,
  input  logic [1:0]         tx_delay,
  input  logic [2:0]         tx_wlen,
  input  logic [BLK_W-1:0]   tx_blk_a,
  input  logic [BLK_W-1:0]   tx_blk_b,
  input  logic [PART_CH-1:0] tx_mask_a,
  input  logic [PART_CH-1:0] tx_mask_b,
  input  logic               rx_bit_tick,
  input  logic               rx_fsync,
  input  logic               rx_fs_invert,
  input  logic [1:0]         rx_delay,
  input  logic [2:0]         rx_wlen,
  input  logic [BLK_W-1:0]   rx_blk_a,
  input  logic [BLK_W-1:0]   rx_blk_b,
  input  logic [PART_CH-1:0] rx_mask_a,
  input  logic [PART_CH-1:0] rx_mask_b,
  output logic [SLOT_W-1:0]  tx_slot,
  output logic               tx_word_start,
  output logic               tx_word_end,
  output logic               tx_slot_en,
  output logic               tx_data_en,
  output logic [SLOT_W-1:0]  rx_slot,
  output logic               rx_word_start,
  output logic               rx_word_end,
  output logic               rx_slot_en,
  output logic               rx_word_take
);
  localparam int NDIR = 2;   // index 0 transmit, index 1 receive

  logic [NDIR-1:0]              tick_v, fs_v, inv_v;
  logic [NDIR-1:0][1:0]         dly_v;
  logic [NDIR-1:0][2:0]         wl_v;
  logic [NDIR-1:0][BLK_W-1:0]   ba_v, bb_v;
  logic [NDIR-1:0][PART_CH-1:0] ma_v, mb_v;
  logic [NDIR-1:0][SLOT_W-1:0]  slot_v;
  logic [NDIR-1:0]              ws_v, we_v, se_v, xf_v, evt_v;

  // named internal events for the checker
  logic tx_bit_evt, rx_bit_evt;

  assign tick_v = {rx_bit_tick, tx_bit_tick};
  assign fs_v   = {rx_fsync, tx_fsync};
  assign inv_v  = {rx_fs_invert, tx_fs_invert};
  assign dly_v  = {rx_delay, tx_delay};
  assign wl_v   = {rx_wlen, tx_wlen};
  assign ba_v   = {rx_blk_a, tx_blk_a};
  assign bb_v   = {rx_blk_b, tx_blk_b};
  assign ma_v   = {rx_mask_a, tx_mask_a};
  assign mb_v   = {rx_mask_b, tx_mask_b};

  for (genvar d = 0; d < NDIR; d++) begin : g_dir
    logic              bit_evt, evt_first, evt_last, enabled;
    logic [SLOT_W-1:0] evt_slot;

    tdm_frame_tracker #(.NUM_SLOTS(NUM_SLOTS), .MAX_WLEN(MAX_WLEN)) u_trk (
      .clk(clk), .rst_n(rst_n), .tick(tick_v[d]), .fsync(fs_v[d]),
      .fs_invert(inv_v[d]), .delay(dly_v[d]), .wlen(wl_v[d]),
      .bit_evt(bit_evt), .evt_slot(evt_slot),
      .evt_first(evt_first), .evt_last(evt_last)
    );

    tdm_chan_map #(.NUM_SLOTS(NUM_SLOTS), .PART_CH(PART_CH)) u_map (
      .slot(evt_slot), .blk_a(ba_v[d]), .blk_b(bb_v[d]),
      .mask_a(ma_v[d]), .mask_b(mb_v[d]), .enabled(enabled)
    );

    tdm_out_stage #(.SLOT_W(SLOT_W), .IS_TX(d == 0)) u_out (
      .clk(clk), .rst_n(rst_n), .tick(tick_v[d]), .bit_evt(bit_evt),
      .evt_slot(evt_slot), .evt_first(evt_first), .evt_last(evt_last),
      .enabled(enabled), .slot_idx(slot_v[d]), .word_start(ws_v[d]),
      .word_end(we_v[d]), .slot_en(se_v[d]), .xfer(xf_v[d])
    );

    assign evt_v[d] = bit_evt;
  end

  assign tx_bit_evt    = evt_v[0];
  assign rx_bit_evt    = evt_v[1];
  assign tx_slot       = slot_v[0];
  assign tx_word_start = ws_v[0];
  assign tx_word_end   = we_v[0];
  assign tx_slot_en    = se_v[0];
  assign tx_data_en    = xf_v[0];
  assign rx_slot       = slot_v[1];
  assign rx_word_start = ws_v[1];
  assign rx_word_end   = we_v[1];
  assign rx_slot_en    = se_v[1];
  assign rx_word_take  = xf_v[1];

endmodule

// File: rtl/tdm_slot_selector_chk.sv
`timescale 1ns/1ps
module tdm_slot_selector_chk #(
  parameter int SLOT_W = 7
) (
  input logic              clk,
  input logic              rst_n,
  input logic [SLOT_W-1:0] tx_slot,
  input logic              tx_word_start,
  input logic              tx_word_end,
  input logic              tx_slot_en,
  input logic              tx_data_en,
  input logic [SLOT_W-1:0] rx_slot,
  input logic              rx_word_start,
  input logic              rx_word_end,
  input logic              rx_slot_en,
  input logic              rx_word_take,
  input logic              tx_bit_evt,
  input logic              rx_bit_evt
);
  a_r4_tx_start_end_apart: assert property (@(posedge clk) disable iff (!rst_n)
    !(tx_word_start && tx_word_end));

  a_r4_rx_end_single: assert property (@(posedge clk) disable iff (!rst_n)
    rx_word_end |=> !rx_word_end);

  a_r4_tx_start_after_bit: assert property (@(posedge clk) disable iff (!rst_n)
    tx_word_start |-> $past(tx_bit_evt));

  a_r4_rx_start_after_bit: assert property (@(posedge clk) disable iff (!rst_n)
    rx_word_start |-> $past(rx_bit_evt));

  a_r5_tx_slot_moves_on_start: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(tx_slot) |-> tx_word_start);

  a_r5_rx_slot_moves_on_start: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rx_slot) |-> rx_word_start);

  a_r9_data_en_needs_slot_en: assert property (@(posedge clk) disable iff (!rst_n)
    tx_data_en |-> tx_slot_en);

  a_r9_data_en_rises_on_bit: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_data_en) |-> $past(tx_bit_evt));

  a_r10_take_on_enabled_end: assert property (@(posedge clk) disable iff (!rst_n)
    rx_word_take |-> (rx_word_end && rx_slot_en));

endmodule

bind tdm_slot_selector tdm_slot_selector_chk #(.SLOT_W(SLOT_W)) u_chk (.*);

// File: tb/tdm_slot_selector_tb.sv
`timescale 1ns/1ps
module tdm_slot_selector_tb;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic        tx_bit_tick = 0, tx_fsync = 0, tx_fs_invert = 0;
  logic [1:0]  tx_delay = 0;
  logic [2:0]  tx_wlen = 0, tx_blk_a = 0, tx_blk_b = 0;
  logic [15:0] tx_mask_a = 0, tx_mask_b = 0;
  logic        rx_bit_tick = 0, rx_fsync = 0, rx_fs_invert = 0;
  logic [1:0]  rx_delay = 0;
  logic [2:0]  rx_wlen = 0, rx_blk_a = 0, rx_blk_b = 0;
  logic [15:0] rx_mask_a = 0, rx_mask_b = 0;
  logic [6:0]  tx_slot, rx_slot;
  logic tx_word_start, tx_word_end, tx_slot_en, tx_data_en;
  logic rx_word_start, rx_word_end, rx_slot_en, rx_word_take;

  tdm_slot_selector u_dut (.*);

  int nchk = 0;
  int nfail = 0;
  string scen = "reset";

  // model state per direction (0 tx, 1 rx)
  int  m_t[2], m_dly[2], m_wl[2], m_blka[2], m_blkb[2];
  bit  m_act[2], m_inv[2];
  bit [15:0] m_ma[2], m_mb[2];
  int  e_slot[2];
  bit  e_ws[2], e_we[2], e_se[2], e_xf[2];

  task automatic chk(input string req, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s [%s] actual=%0d expected=%0d at %0t", req, scen, act, exp, $time);
    end
  endtask

  function automatic bit en_f(input int d, input int s);
    int ra, rb;
    bit r = 0;
    ra = s - m_blka[d] * 16;
    rb = s - m_blkb[d] * 16;
    if (ra >= 0 && ra < 16) if (m_ma[d][ra]) r = 1;
    if (rb >= 0 && rb < 16) if (m_mb[d][rb]) r = 1;
    return r;
  endfunction

  function automatic int wl_of(input int c);
    case (c)
      0: return 8;  1: return 12; 2: return 16;
      3: return 20; 4: return 24; default: return 32;
    endcase
  endfunction

  task automatic cfg(input int d, input int dc, input int wc, input int ba, input int bb,
                     input bit [15:0] ma, input bit [15:0] mb, input bit inv);
    m_dly[d] = (dc == 3) ? 2 : dc;
    m_wl[d] = wl_of(wc);
    m_blka[d] = ba; m_blkb[d] = bb; m_ma[d] = ma; m_mb[d] = mb; m_inv[d] = inv;
    if (d == 0) begin
      tx_delay = 2'(dc); tx_wlen = 3'(wc); tx_blk_a = 3'(ba); tx_blk_b = 3'(bb);
      tx_mask_a = ma; tx_mask_b = mb; tx_fs_invert = inv;
    end else begin
      rx_delay = 2'(dc); rx_wlen = 3'(wc); rx_blk_a = 3'(ba); rx_blk_b = 3'(bb);
      rx_mask_a = ma; rx_mask_b = mb; rx_fs_invert = inv;
    end
  endtask

  task automatic model(input int d, input bit tk, input bit sy);
    int dd;
    e_ws[d] = 0; e_we[d] = 0;
    if (d == 1) e_xf[d] = 0;
    if (!tk) return;
    if (sy) begin m_act[d] = 1; m_t[d] = 0; end
    else if (m_act[d]) m_t[d]++;
    if (d == 0) e_xf[d] = 0;
    if (!m_act[d]) return;
    dd = m_t[d] - m_dly[d];
    if (dd >= 0 && dd / m_wl[d] < 128) begin
      e_slot[d] = dd / m_wl[d];
      e_ws[d] = (dd % m_wl[d]) == 0;
      e_we[d] = (dd % m_wl[d]) == m_wl[d] - 1;
      e_se[d] = en_f(d, e_slot[d]);
      e_xf[d] = (d == 0) ? e_se[d] : (e_we[d] && e_se[d]);
    end
  endtask

  task automatic compare_all();
    chk("R5 tx_slot", tx_slot, e_slot[0]);
    chk("R4 tx_word_start", tx_word_start, e_ws[0]);
    chk("R4 tx_word_end", tx_word_end, e_we[0]);
    chk("R8 tx_slot_en", tx_slot_en, e_se[0]);
    chk("R9 tx_data_en", tx_data_en, e_xf[0]);
    chk("R5 rx_slot", rx_slot, e_slot[1]);
    chk("R4 rx_word_start", rx_word_start, e_ws[1]);
    chk("R4 rx_word_end", rx_word_end, e_we[1]);
    chk("R8 rx_slot_en", rx_slot_en, e_se[1]);
    chk("R10 rx_word_take", rx_word_take, e_xf[1]);
  endtask

  // one bit step: tick for one clock, read after the sampling edge, then one idle clock
  task automatic step(input bit tk0, input bit sy0, input bit tk1, input bit sy1);
    @(negedge clk);
    tx_bit_tick = tk0; tx_fsync = sy0 ^ m_inv[0];
    rx_bit_tick = tk1; rx_fsync = sy1 ^ m_inv[1];
    @(negedge clk);
    tx_bit_tick = 0; rx_bit_tick = 0;
    tx_fsync = ~m_inv[0]; rx_fsync = ~m_inv[1];  // non-tick sync level must be ignored (R2)
    model(0, tk0, sy0);
    model(1, tk1, sy1);
    compare_all();
  endtask

  initial begin
    #(150000 * 5);
    nfail++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end

  initial begin
    for (int d = 0; d < 2; d++) begin
      m_t[d] = 0; m_act[d] = 0; m_inv[d] = 0; e_slot[d] = 0;
      e_ws[d] = 0; e_we[d] = 0; e_se[d] = 0; e_xf[d] = 0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1: reset state
    compare_all();
    chk("R1 tx_slot after reset", tx_slot, 0);
    // R1: no sync yet, ticks count nothing
    scen = "R1 ticks before any sync";
    cfg(0, 0, 0, 0, 1, 16'hFFFF, 16'hFFFF, 0);
    cfg(1, 0, 0, 0, 1, 16'hFFFF, 16'hFFFF, 0);
    for (int i = 0; i < 6; i++) step(1, 0, 1, 0);

    // R3 and R4 sweep, rx run with mirrored settings and opposite polarity (R2)
    scen = "R3 R4 R2 delay/length/polarity sweep";
    for (int wc = 0; wc < 8; wc++) begin
      for (int dc = 0; dc < 4; dc++) begin
        cfg(0, dc, wc, wc % 2, (wc + 1) % 2, 16'hA5C3 ^ 16'(wc * 16'h1111),
            16'h3C96 ^ 16'(dc * 16'h0F0F), bit'(dc % 2));
        cfg(1, 3 - dc, 7 - wc, (wc + 1) % 2, wc % 2, 16'h5A3C ^ 16'(dc * 16'h1248),
            16'hC381 ^ 16'(wc * 16'h2222), bit'((dc + 1) % 2));
        step(1, 1, 1, 1);
        for (int i = 0; i < 12 * 32 + 2; i++) step(1, 0, 1, 0);
      end
    end

    // R6: full 128-slot frame, partitions in high and middle blocks
    scen = "R6 frame end after slot 127";
    cfg(0, 0, 0, 7, 3, 16'h8421, 16'hF00F, 0);
    cfg(1, 1, 0, 3, 7, 16'h1248, 16'h8001, 1);
    step(1, 1, 1, 1);
    for (int i = 0; i < 128 * 8 + 12; i++) step(1, 0, 1, 0);
    chk("R6 tx no word after frame end", tx_word_start, 0);

    // R7: sync inside a word restarts at slot 0
    scen = "R7 mid-frame resync";
    cfg(0, 2, 1, 0, 2, 16'hFFF0, 16'h0FFF, 1);
    cfg(1, 0, 0, 1, 0, 16'hAAAA, 16'h5555, 0);
    step(1, 1, 1, 1);
    for (int i = 0; i < 45; i++) step(1, 0, 1, 0);
    step(1, 1, 1, 1);
    chk("R7 rx restart slot", rx_slot, 0);
    for (int i = 0; i < 40; i++) step(1, 0, 1, 0);

    // R11: transmit activity leaves receive outputs unchanged
    scen = "R11 tx only, rx idle";
    cfg(0, 1, 2, 0, 0, 16'h0F0F, 16'h00F0, 0);
    step(1, 1, 0, 0);
    for (int i = 0; i < 40; i++) step(1, 0, 0, 0);
    chk("R11 rx_slot held", rx_slot, e_slot[1]);
    scen = "R11 rx only, tx idle";
    cfg(1, 0, 0, 0, 1, 16'hFFFF, 16'h0000, 0);
    step(0, 0, 1, 1);
    for (int i = 0; i < 30; i++) step(0, 0, 1, 0);
    chk("R11 tx_data_en held", tx_data_en, e_xf[0]);

    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end

endmodule